// File: doc/BRIEF.md
# Serial Register-Port Slave with Frame-Length Guard

This block is the serial slave port of a system-controller register file. A host drives an active-low chip select, a serial clock that idles low, and a data line. The block brings these three pins into the system clock domain through two-flop synchronisers and finds the clock edges there. It takes a 16-bit word in, MSB first, and shifts a read word out on a tri-stated data line. The read word is captured from the register file at the moment chip select falls.

Inside each chip-select window the block counts serial clock periods. The count saturates, so over-long frames are still recognised. When chip select rises, the block decides what to do with the frame. With exactly 16 periods it commits the write. With any other count it throws the frame away and raises a failure. The failure is an interrupt, which can be masked, in the normal modes. It is a reset request instead while the controller is in a start-up class mode. An external reset-input level gates every access.

Top module: `spi_fc_slave`

## Requirements
- R1: `sdo_oe_o` is 0 while chip select is high and after reset; it is 1 during a window that opened with `rstin_i` high.
- R2: `sdo_o` presents `rd_data_i` (captured at chip-select fall) MSB first; bit 15 is valid before the first SCK rising edge, and each later bit follows an SCK falling edge.
- R3: SDI is sampled on SCK rising edges; in the received word, bits 15:12 are the register address, bit 11 is the read-only flag and bits 10:0 are the write data.
- R4: A window with exactly 16 SCK periods and the read-only flag clear gives exactly one `wr_en_o` pulse, carrying that address and data.
- R5: A window with any other number of SCK periods (0, fewer than 16, more than 16, up to far beyond 16) gives no write.
- R6: When a failed window ends with `startup_i` low, `fail_irq_o` pulses once if `fail_irq_en_i` is 1, and nothing is raised if it is 0.
- R7: When a failed window ends with `startup_i` high, `rst_req_o` pulses once and `fail_irq_o` stays low, whatever the enable.
- R8: A 16-period frame with the read-only flag set writes nothing and raises no failure; its data field has no effect.
- R9: If `rstin_i` is low when chip select falls, or drops at any point in the window, the frame is ignored: no write, no failure, SDO stays disabled.
- R10: `wr_en_o`, `fail_irq_o` and `rst_req_o` are single-cycle pulses, and a write never comes together with a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| rstin_i | input | 1 | Reset-input level; access allowed while high |
| startup_i | input | 1 | Controller is in a start-up or restart mode |
| fail_irq_en_i | input | 1 | Enable for the frame-failure interrupt |
| rd_data_i | input | 16 | Read word shifted out in the next frame |
| wr_en_o | output | 1 | Write commit pulse |
| wr_addr_o | output | 4 | Committed register address |
| wr_data_o | output | 11 | Committed write data |
| fail_irq_o | output | 1 | Frame-failure interrupt pulse |
| rst_req_o | output | 1 | Frame-failure reset request pulse |

## Verification
A bit counter that is off by one shows up at chip-select rise. A true 16-period frame then raises a failure instead of a write, or a 15- or 17-period frame commits. The sweep over every count from 0 to 18, plus one very long frame, exposes this at the next decision. A wrong shift register or capture point shows on the very next frame, either as a misplaced bit on `sdo_o` or as a wrong `wr_addr_o` or `wr_data_o`. An access gate that does not clear shows as a write, or as SDO enabled, during a frame with the reset input low.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = FRAME_W - ADDR_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd_only;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [1:0] {
    VERDICT_IDLE,
    VERDICT_COMMIT,
    VERDICT_QUIET,
    VERDICT_FAIL
  } verdict_e;
endpackage

// File: rtl/spi_fc_sync.sv
module spi_fc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fc_shifter.sv
module spi_fc_shifter
  import spi_fc_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scs_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          rstin_i,
  input  logic [FW-1:0] rd_data_i,
  output logic [FW-1:0] rx_word,
  output logic [CW-1:0] bit_cnt,
  output logic          active,
  output logic          cs_rise,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam logic [CW-1:0] CNT_SAT = CW'(FW + 1);

  logic          sck_d, scs_d;
  logic          sck_rise, sck_fall, cs_fall;
  logic [FW-1:0] tx_sh;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~scs_s & scs_d;
  assign cs_rise  = scs_s & ~scs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      scs_d   <= 1'b1;
      active  <= 1'b0;
      bit_cnt <= '0;
      rx_word <= '0;
      tx_sh   <= '0;
      sdo_oe  <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      scs_d  <= scs_s;
      sdo_oe <= active;
      if (cs_fall && rstin_i) begin
        active  <= 1'b1;
        bit_cnt <= '0;
        tx_sh   <= rd_data_i;
      end else if (scs_s || !rstin_i) begin
        active <= 1'b0;
      end else if (active) begin
        if (sck_rise) begin
          rx_word <= {rx_word[FW-2:0], sdi_s};
          if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) tx_sh <= {tx_sh[FW-2:0], 1'b0};
      end
    end
  end

  assign sdo = tx_sh[FW-1];
endmodule

// File: rtl/spi_fc_judge.sv
module spi_fc_judge
  import spi_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_rise,
  input  logic              active,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  frame_t            rx_frame,
  input  logic              startup_i,
  input  logic              irq_en_i,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fail_irq,
  output logic              rst_req
);
  verdict_e verdict;

  always_comb begin
    verdict = VERDICT_IDLE;
    if (cs_rise && active) begin
      if (bit_cnt != CNT_W'(FRAME_W)) verdict = VERDICT_FAIL;
      else if (rx_frame.rd_only)      verdict = VERDICT_QUIET;
      else                            verdict = VERDICT_COMMIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      fail_irq <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      fail_irq <= 1'b0;
      rst_req  <= 1'b0;
      case (verdict)
        VERDICT_COMMIT: begin
          wr_en   <= 1'b1;
          wr_addr <= rx_frame.addr;
          wr_data <= rx_frame.data;
        end
        VERDICT_FAIL: begin
          if (startup_i)     rst_req  <= 1'b1;
          else if (irq_en_i) fail_irq <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_fc_slave.sv
module spi_fc_slave
  import spi_fc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               scs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  input  logic               rstin_i,
  input  logic               startup_i,
  input  logic               fail_irq_en_i,
  input  logic [FRAME_W-1:0] rd_data_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               fail_irq_o,
  output logic               rst_req_o
);
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] rx_word;
  logic [CNT_W-1:0]   bit_cnt;
  logic               active, cs_rise;

  spi_fc_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sdi_i, sck_i, scs_n_i}),
    .q   (pins_s)
  );

  spi_fc_shifter #(.FW(FRAME_W), .CW(CNT_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .scs_s     (pins_s[0]),
    .sck_s     (pins_s[1]),
    .sdi_s     (pins_s[2]),
    .rstin_i   (rstin_i),
    .rd_data_i (rd_data_i),
    .rx_word   (rx_word),
    .bit_cnt   (bit_cnt),
    .active    (active),
    .cs_rise   (cs_rise),
    .sdo       (sdo_o),
    .sdo_oe    (sdo_oe_o)
  );

  spi_fc_judge i_judge (
    .clk       (clk),
    .rst       (rst),
    .cs_rise   (cs_rise),
    .active    (active),
    .bit_cnt   (bit_cnt),
    .rx_frame  (frame_t'(rx_word)),
    .startup_i (startup_i),
    .irq_en_i  (fail_irq_en_i),
    .wr_en     (wr_en_o),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o),
    .fail_irq  (fail_irq_o),
    .rst_req   (rst_req_o)
  );
endmodule

// File: rtl/spi_fc_checker.sv
module spi_fc_checker (
  input logic clk,
  input logic rst,
  input logic scs_n_i,
  input logic sdo_oe_o,
  input logic rstin_i,
  input logic startup_i,
  input logic fail_irq_en_i,
  input logic wr_en_o,
  input logic fail_irq_o,
  input logic rst_req_o
);
  a_r1_oe_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(scs_n_i, 1) && $past(scs_n_i, 2) && $past(scs_n_i, 3) && $past(scs_n_i, 4))
      |-> !sdo_oe_o);

  a_r6_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    fail_irq_o |-> $past(fail_irq_en_i));

  a_r7_no_irq_startup: assert property (@(posedge clk) disable iff (rst)
    fail_irq_o |-> !$past(startup_i));

  a_r7_reset_in_startup: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(startup_i));

  a_r9_gate: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o || fail_irq_o || rst_req_o) |-> $past(rstin_i, 2));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_en_o, fail_irq_o, rst_req_o}) <= 1);

  a_r10_write_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  a_r10_fail_pulse: assert property (@(posedge clk) disable iff (rst)
    (fail_irq_o || rst_req_o) |=> !(fail_irq_o || rst_req_o));
endmodule

bind spi_fc_slave spi_fc_checker i_chk (
  .clk           (clk),
  .rst           (rst),
  .scs_n_i       (scs_n_i),
  .sdo_oe_o      (sdo_oe_o),
  .rstin_i       (rstin_i),
  .startup_i     (startup_i),
  .fail_irq_en_i (fail_irq_en_i),
  .wr_en_o       (wr_en_o),
  .fail_irq_o    (fail_irq_o),
  .rst_req_o     (rst_req_o)
);

// File: tb/test_spi_fc_slave.sv
module test_spi_fc_slave;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        scs_n, sck, sdi, rstin, startup, irq_en;
  logic [15:0] rd_data;
  logic        sdo, sdo_oe, wr_en, fail_irq, rst_req;
  logic [3:0]  wr_addr;
  logic [10:0] wr_data;

  int errors = 0;
  int checks = 0;
  int n_wr = 0, n_irq = 0, n_rst = 0;
  logic [3:0]  last_addr;
  logic [10:0] last_data;
  bit done = 0;

  always #5 clk = ~clk;

  spi_fc_slave i_spi_fc_slave (
    .clk (clk), .rst (rst), .scs_n_i (scs_n), .sck_i (sck), .sdi_i (sdi),
    .sdo_o (sdo), .sdo_oe_o (sdo_oe), .rstin_i (rstin), .startup_i (startup),
    .fail_irq_en_i (irq_en), .rd_data_i (rd_data), .wr_en_o (wr_en),
    .wr_addr_o (wr_addr), .wr_data_o (wr_data), .fail_irq_o (fail_irq),
    .rst_req_o (rst_req)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin n_wr++; last_addr = wr_addr; last_data = wr_data; end
      if (fail_irq) n_irq++;
      if (rst_req)  n_rst++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One chip-select window with nclk SCK periods; drop_at>=0 pulls rstin low after that bit.
  task automatic frame(input int nclk, input logic [15:0] word, input logic [15:0] rdw,
                       input bit gate, input int drop_at);
    int  w0 = n_wr, i0 = n_irq, r0 = n_rst;
    int  sdo_bad = 0;
    bit  ok16, fail, dropped;
    rd_data = rdw;
    rstin   = gate;
    scs_n   = 1'b0;
    idle(8);
    check(sdo_oe == gate, "R1", "oe in window", sdo_oe, gate);
    dropped = !gate;
    for (int b = 0; b < nclk; b++) begin
      sdi = (b < 16) ? word[15-b] : 1'b0;
      idle(HALF);
      if (b < 16 && gate && !dropped && sdo !== rdw[15-b]) sdo_bad++;
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
      if (b == drop_at) begin rstin = 1'b0; dropped = 1; end
    end
    idle(HALF);
    if (gate && !dropped)
      check(sdo_bad == 0, "R2", "sdo bit mismatches", sdo_bad, 0);
    scs_n = 1'b1;
    idle(10);
    rstin = 1'b1;
    check(sdo_oe == 1'b0, "R1", "oe after window", sdo_oe, 0);
    ok16 = (nclk == 16) && !dropped;
    fail = (nclk != 16) && !dropped;
    if (dropped) begin
      check((n_wr - w0) + (n_irq - i0) + (n_rst - r0) == 0, "R9", "gated frame outputs",
            (n_wr - w0) + (n_irq - i0) + (n_rst - r0), 0);
    end else if (ok16 && word[11]) begin
      check((n_wr - w0) + (n_irq - i0) + (n_rst - r0) == 0, "R8", "read-only frame outputs",
            (n_wr - w0) + (n_irq - i0) + (n_rst - r0), 0);
    end else if (ok16) begin
      check(n_wr - w0 == 1, "R4", "write count", n_wr - w0, 1);
      check(last_addr == word[15:12], "R3", "address", last_addr, word[15:12]);
      check(last_data == word[10:0], "R3", "data", last_data, word[10:0]);
      check(n_irq == i0 && n_rst == r0, "R10", "no failure with write", n_irq - i0, 0);
    end else begin
      check(n_wr == w0, "R5", "no write on bad count", n_wr - w0, 0);
      if (startup) begin
        check(n_rst - r0 == 1, "R7", "reset request", n_rst - r0, 1);
        check(n_irq == i0, "R7", "no irq in startup", n_irq - i0, 0);
      end else begin
        check(n_irq - i0 == int'(irq_en), "R6", "irq vs enable", n_irq - i0, irq_en);
        check(n_rst == r0, "R6", "no reset request", n_rst - r0, 0);
      end
    end
  endtask

  initial begin
    rst = 1'b1; scs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    rstin = 1'b1; startup = 1'b0; irq_en = 1'b0; rd_data = '0;
    idle(5);
    rst = 1'b0;
    idle(3);
    check(sdo_oe == 1'b0, "R1", "reset oe", sdo_oe, 0);
    check(wr_en == 1'b0 && fail_irq == 1'b0 && rst_req == 1'b0, "R10", "reset pulses",
          {wr_en, fail_irq, rst_req}, 0);

    // Sweep SCK count against every mode combination.
    for (int m = 0; m < 4; m++) begin
      startup = m[1];
      irq_en  = m[0];
      for (int n = 0; n <= 19; n++) begin
        int nn = (n == 19) ? 40 : n;
        logic [15:0] w  = {4'(n + m), 1'b0, 11'((n * 293 + m * 71) ^ 11'h2A5)};
        logic [15:0] rw = 16'(16'hA5C3 ^ (n * 16'h0F31) ^ (m << 9));
        frame(nn, w, rw, 1'b1, -1);
      end
    end

    // Data patterns on full frames.
    startup = 1'b0; irq_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      logic [15:0] w = {4'(k), 1'b0, 11'(11'h7FF >> (k % 11)) ^ 11'(k * 5)};
      frame(16, w, ~w, 1'b1, -1);
    end
    frame(16, 16'hFFFF & ~16'h0800, 16'h0000, 1'b1, -1);
    frame(16, 16'h0000, 16'hFFFF, 1'b1, -1);

    // Read-only flag: no write, no failure, data field irrelevant.
    frame(16, 16'h3FFF, 16'h1234, 1'b1, -1);
    frame(16, 16'h0800, 16'h8001, 1'b1, -1);
    startup = 1'b1;
    frame(16, 16'hA9AA, 16'h5555, 1'b1, -1);

    // Reset input low for the whole frame, and dropping mid-frame.
    frame(16, 16'h5123, 16'hC3C3, 1'b0, -1);
    frame(15, 16'h5123, 16'hC3C3, 1'b0, -1);
    startup = 1'b0; irq_en = 1'b1;
    frame(16, 16'h6456, 16'h3C3C, 1'b1, 7);
    frame(12, 16'h6456, 16'h3C3C, 1'b1, 3);

    // Good frame after the gated ones still commits.
    frame(16, 16'h9123, 16'h0F0F, 1'b1, -1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule